// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block connects a synchronous byte request port to an asynchronous DRAM module whose row and column addresses share one set of address pins and whose strobes (row strobe, column strobe, write enable) are active low. A request carries a linear address, a direction and, for writes, one byte. The controller splits the address into a row and a column at a point chosen at runtime, plays out the strobe sequence one phase at a time, drives the write byte or samples the read byte, and reports read data with a one-cycle done pulse.

When no request has been accepted for a programmable number of idle cycles, the controller runs a refresh with the column strobe asserted ahead of the row strobe. This needs no address and strobes every enabled row-strobe bank line together. Two bank lines exist. Normal accesses only use bank line 0. The address-bit count and the bank count are runtime settings that reject out-of-range values. Every strobe phase lasts `PH_CYC` clock cycles.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset, `dram_ras_n` = 2'b11, `dram_cas_n` = 1, `dram_we_n` = 1, `dram_dq_oe` = 0, `rd_done` = 0 and `req_ready` = 1.
- R2: With an address-bit setting N, the row put on `dram_addr` is (addr >> N) masked to its low N bits, and the column is the low N bits of addr. All `dram_addr` bits at or above N are 0.
- R3: An access puts the row on `dram_addr` and then drops `dram_ras_n[0]`. It then puts the column on `dram_addr` and drops `dram_cas_n`. It then raises `dram_ras_n[0]` while `dram_cas_n` is still low, and raises `dram_cas_n` last.
- R4: On a write, `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_o` carries the byte before `dram_ras_n[0]` falls. Both stay so until the strobes are released. Once the block is ready again, `dram_we_n` is 1 and `dram_dq_oe` is 0.
- R5: On a read, `dram_we_n` stays 1 and `dram_dq_oe` stays 0. `dram_dq_i` is captured at the last clock edge of the phase in which both `dram_ras_n[0]` and `dram_cas_n` are low. `rd_data` holds that byte, and `rd_done` is high for exactly one cycle.
- R6: A refresh drops `dram_cas_n` while both row strobes are high, then drops the row strobes, then raises `dram_cas_n`, then raises the row strobes.
- R7: An access never drives `dram_ras_n[1]` low. A refresh drives `dram_ras_n` to 2'b10 with a bank count of 1, and to 2'b00 with a bank count of 2.
- R8: A write to the configuration port with `cfg_sel` = 0 sets the address-bit count to `cfg_val` if it lies in 1..MAX_ABITS (12 by default). Any other value leaves the count unchanged. The reset value is MAX_ABITS.
- R9: A write to the configuration port with `cfg_sel` = 1 sets the bank count to `cfg_val` if it is 1 or 2. Any other value leaves it unchanged. The reset value is 1.
- R10: After REF_IDLE consecutive idle cycles with no accepted request, `req_ready` drops. The refresh column strobe falls on the next cycle, so a refresh that is due takes priority over a request.
- R11: Each strobe phase lasts PH_CYC cycles. In particular, `dram_ras_n[0]` is low for PH_CYC cycles before `dram_cas_n` falls.
- R12: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after it is taken and for the rest of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MAX_ABITS | Linear byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_done | output | 1 | One-cycle pulse when read data is valid |
| rd_data | output | DATA_W | Last byte read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = address-bit count, 1 = bank count |
| cfg_val | input | NB_W | Value proposed for the selected setting |
| dram_addr | output | MAX_ABITS | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per bank, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_i | input | DATA_W | Data returned by the DRAM |

## Verification
The bench builds the controller with PH_CYC = 3 and REF_IDLE = 12, and keeps MAX_ABITS at 12. With three cycles per phase, the bench can measure the row-to-column strobe spacing and can tell the last cycle of the column phase apart from earlier ones, because its DRAM model changes the returned byte every cycle of that phase. The short idle interval lets several refreshes happen between directed accesses, so both bank patterns and the refresh-versus-request priority can be reached within a few hundred cycles. The address splits at 12, 8 and 1 bits cover the widest setting, a middle setting and the narrowest one.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM access controller.
// Assumes: one sequencer state register, one state active at a time.
package dram_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROW,
        ST_COL,
        ST_RREL,
        ST_CREL,
        ST_RF_CAS,
        ST_RF_RAS,
        ST_RF_CREL
    } seq_state_e;
endpackage

// File: rtl/dram_phase_timer.sv
`timescale 1ns/1ps
// Phase length counter: flags the last cycle of every PH_CYC-cycle strobe phase.
// Assumes: run is low only in the idle state; PH_CYC >= 1.
module dram_phase_timer #(
    parameter int PH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(PH_CYC - 1));

    // Count cycles within the current phase, restarting at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_idle_timer.sv
`timescale 1ns/1ps
// Idle interval counter: raises due after REF_IDLE consecutive idle cycles.
// Assumes: idle drops whenever the sequencer leaves the idle state; REF_IDLE >= 1.
module dram_idle_timer #(
    parameter int REF_IDLE = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    output logic due
);
    localparam int IW = $clog2(REF_IDLE + 1);

    logic [IW-1:0] cnt;

    assign due = (cnt == IW'(REF_IDLE));

    // Count idle cycles, saturating at the interval and clearing on any activity.
    always_ff @(posedge clk) begin
        if (!rst_n || !idle) cnt <= '0;
        else if (!due)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_cfg_regs.sv
`timescale 1ns/1ps
// Runtime settings: address-bit count (1..MAX_ABITS) and bank count (1 or 2).
// Assumes: an out-of-range write is dropped silently, keeping the old value.
module dram_cfg_regs #(
    parameter int MAX_ABITS = 12,
    parameter int NB_W      = $clog2(MAX_ABITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [NB_W-1:0] cfg_val,
    output logic [NB_W-1:0] abits,
    output logic            dual_bank
);
    logic abits_ok;
    logic banks_ok;

    assign abits_ok = (cfg_val != '0) && (cfg_val <= NB_W'(MAX_ABITS));
    assign banks_ok = (cfg_val == NB_W'(1)) || (cfg_val == NB_W'(2));

    // Accept an in-range address-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n)                           abits <= NB_W'(MAX_ABITS);
        else if (cfg_we && !cfg_sel && abits_ok) abits <= cfg_val;
    end

    // Accept a bank count of 1 or 2.
    always_ff @(posedge clk) begin
        if (!rst_n)                           dual_bank <= 1'b0;
        else if (cfg_we && cfg_sel && banks_ok)  dual_bank <= (cfg_val == NB_W'(2));
    end
endmodule

// File: rtl/dram_addr_split.sv
`timescale 1ns/1ps
// Splits a linear address into row and column fields at a runtime bit count.
// Assumes: abits <= MAX_ABITS; purely combinational.
module dram_addr_split #(
    parameter int MAX_ABITS = 12,
    parameter int NB_W      = $clog2(MAX_ABITS + 1)
) (
    input  logic [2*MAX_ABITS-1:0] addr,
    input  logic [NB_W-1:0]        abits,
    output logic [MAX_ABITS-1:0]   row,
    output logic [MAX_ABITS-1:0]   col
);
    logic [MAX_ABITS-1:0] mask;
    logic [2*MAX_ABITS-1:0] shifted;

    // Build the field mask and both fields.
    always_comb begin
        mask    = ~({MAX_ABITS{1'b1}} << abits);
        shifted = addr >> abits;
        row     = shifted[MAX_ABITS-1:0] & mask;
        col     = addr[MAX_ABITS-1:0] & mask;
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
// DRAM access controller top: takes byte requests, runs row/column strobe
// sequences on bank 0, and fills idle time with column-first refresh cycles.
// Assumes: asynchronous DRAM without page mode; strobe outputs are decoded
// from the registered state; the data bus is split into out/enable/in.
module dram_seq_ctrl #(
    parameter int MAX_ABITS = 12,
    parameter int DATA_W    = 8,
    parameter int PH_CYC    = 2,
    parameter int REF_IDLE  = 200,
    parameter int NB_W      = $clog2(MAX_ABITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [2*MAX_ABITS-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rd_done,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [NB_W-1:0]        cfg_val,
    output logic [MAX_ABITS-1:0]   dram_addr,
    output logic [1:0]             dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic [DATA_W-1:0]      dram_dq_o,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_i
);
    import dram_seq_pkg::*;

    seq_state_e           st, nxt;
    logic                 last, due, take, in_acc;
    logic [NB_W-1:0]      abits;
    logic                 dual_bank;
    logic [MAX_ABITS-1:0] row_w, col_w, row_q, col_q;
    logic                 wr_q;
    logic [DATA_W-1:0]    wd_q;
    logic [1:0]           rf_ras_n;

    dram_cfg_regs #(.MAX_ABITS(MAX_ABITS), .NB_W(NB_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .abits(abits), .dual_bank(dual_bank)
    );

    dram_addr_split #(.MAX_ABITS(MAX_ABITS), .NB_W(NB_W)) u_split (
        .addr(req_addr), .abits(abits), .row(row_w), .col(col_w)
    );

    dram_phase_timer #(.PH_CYC(PH_CYC)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .last(last)
    );

    dram_idle_timer #(.REF_IDLE(REF_IDLE)) u_idle (
        .clk(clk), .rst_n(rst_n), .idle(st == ST_IDLE), .due(due)
    );

    assign req_ready = (st == ST_IDLE) && !due;
    assign take      = req_valid && req_ready;
    assign in_acc    = (st == ST_SETUP) || (st == ST_ROW) || (st == ST_COL)
                    || (st == ST_RREL)  || (st == ST_CREL);
    assign rf_ras_n  = dual_bank ? 2'b00 : 2'b10;

    // Choose the next sequencer state; refresh wins only once it is due.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:    if (due) nxt = ST_RF_CAS; else if (req_valid) nxt = ST_SETUP;
            ST_SETUP:   if (last) nxt = ST_ROW;
            ST_ROW:     if (last) nxt = ST_COL;
            ST_COL:     if (last) nxt = ST_RREL;
            ST_RREL:    if (last) nxt = ST_CREL;
            ST_CREL:    if (last) nxt = ST_IDLE;
            ST_RF_CAS:  if (last) nxt = ST_RF_RAS;
            ST_RF_RAS:  if (last) nxt = ST_RF_CREL;
            ST_RF_CREL: if (last) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Capture the split address, direction and write byte when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
            wd_q  <= '0;
        end else if (take) begin
            row_q <= row_w;
            col_q <= col_w;
            wr_q  <= req_write;
            wd_q  <= req_wdata;
        end
    end

    // Sample read data at the end of the column phase and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= (st == ST_COL) && last && !wr_q;
            if ((st == ST_COL) && last && !wr_q) rd_data <= dram_dq_i;
        end
    end

    // Decode strobes, address and data drive from the current state.
    always_comb begin
        dram_ras_n = 2'b11;
        dram_cas_n = 1'b1;
        dram_addr  = '0;
        dram_dq_o  = wd_q;
        dram_we_n  = !(in_acc && wr_q);
        dram_dq_oe = in_acc && wr_q;
        case (st)
            ST_SETUP:   dram_addr = row_q;
            ST_ROW:     begin dram_addr = row_q; dram_ras_n[0] = 1'b0; end
            ST_COL:     begin dram_addr = col_q; dram_ras_n[0] = 1'b0; dram_cas_n = 1'b0; end
            ST_RREL:    begin dram_addr = col_q; dram_cas_n = 1'b0; end
            ST_RF_CAS:  dram_cas_n = 1'b0;
            ST_RF_RAS:  begin dram_cas_n = 1'b0; dram_ras_n = rf_ras_n; end
            ST_RF_CREL: dram_ras_n = rf_ras_n;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dram_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the DRAM access controller, bound to the top module.
// Assumes: observes only top-level ports.
module dram_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rd_done,
    input logic [1:0] dram_ras_n,
    input logic       dram_cas_n,
    input logic       dram_we_n,
    input logic       dram_dq_oe
);
    // R1: whenever a request could be taken, all strobes are idle and the bus is released.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n == 2'b11 && dram_cas_n && dram_we_n && !dram_dq_oe));

    // R3 and R6: the column strobe falls either into an open bank-0 row or with both rows closed.
    assert_cas_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ($past(dram_ras_n) == 2'b11 || $past(dram_ras_n) == 2'b10));

    // R4: write enable is only ever low while the data bus is driven.
    assert_we_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_dq_oe);

    // R5: the read done flag is a single-cycle pulse.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7: bank line 1 only falls during refresh, with the column strobe already low.
    assert_bank1_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n[1]) |-> !dram_cas_n);
endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_done(rd_done),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/dram_seq_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for the DRAM access controller with a port-level DRAM monitor.
module dram_seq_ctrl_bench;
    localparam int PH  = 3;
    localparam int RI  = 12;
    localparam int MAB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_done;
    logic [7:0]  rd_data;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [3:0]  cfg_val = '0;
    logic [11:0] dram_addr;
    logic [1:0]  dram_ras_n;
    logic        dram_cas_n, dram_we_n, dram_dq_oe;
    logic [7:0]  dram_dq_o;
    logic [7:0]  dram_dq_i = 8'hEE;

    int checks = 0, fails = 0;
    bit finished = 0;

    dram_seq_ctrl #(.MAX_ABITS(MAB), .DATA_W(8), .PH_CYC(PH), .REF_IDLE(RI)) u_dram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_done(rd_done), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_o(dram_dq_o),
        .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );

    always #5 clk = ~clk;

    // Port monitor and DRAM data model, sampled at the falling edge.
    logic [7:0]  rd_base = 8'h40;
    int          k = 0;
    logic        p_ras0 = 1'b1, p_cas = 1'b1;
    bit          acc = 0, rf = 0;
    logic [11:0] m_row, m_col;
    logic        m_we_ras, m_oe_ras, m_we_cas, m_we_seen, m_oe_seen;
    logic [7:0]  m_wd;
    logic [1:0]  m_rf_ras;
    int          m_ras_cnt = 0, acc_count = 0, rf_count = 0, order_err = 0, bank_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (acc && !dram_ras_n[1]) bank_err++;
            if (acc && !dram_we_n) m_we_seen = 1;
            if (acc && dram_dq_oe) m_oe_seen = 1;
            if (p_ras0 && !dram_ras_n[0] && dram_cas_n) begin
                acc = 1; m_row = dram_addr; m_we_ras = dram_we_n; m_oe_ras = dram_dq_oe;
                m_ras_cnt = 1;
                m_we_seen = !dram_we_n; m_oe_seen = dram_dq_oe;
                if (!dram_ras_n[1]) bank_err++;
            end else if (acc && !dram_ras_n[0] && dram_cas_n) begin
                m_ras_cnt++;
            end
            if (acc && p_cas && !dram_cas_n) begin
                m_col = dram_addr; m_wd = dram_dq_o; m_we_cas = dram_we_n;
            end
            if (acc && !p_ras0 && dram_ras_n[0] && dram_cas_n) order_err++;
            if (acc && !p_cas && dram_cas_n) begin
                if (!dram_ras_n[0]) order_err++;
                acc = 0; acc_count++;
            end
            if (!acc && !rf && p_cas && !dram_cas_n && dram_ras_n == 2'b11) rf = 1;
            if (rf && p_ras0 && !dram_ras_n[0]) m_rf_ras = dram_ras_n;
            if (rf && !p_cas && dram_cas_n && dram_ras_n[0]) order_err++;
            if (rf && !p_ras0 && dram_ras_n[0]) begin
                if (!dram_cas_n) order_err++;
                rf = 0; rf_count++;
            end
        end
        if (!dram_ras_n[0] && !dram_cas_n) begin
            k++; dram_dq_i = rd_base + 8'(k);
        end else begin
            k = 0; dram_dq_i = 8'hEE;
        end
        p_ras0 = dram_ras_n[0];
        p_cas  = dram_cas_n;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [3:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_val = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wait_refreshes(input int n);
        int start = rf_count;
        for (int i = 0; i < 2000 && rf_count < start + n; i++) @(negedge clk);
        #1;
    endtask

    // Issue one request and wait until its strobe sequence has ended.
    task automatic run_access(input logic wr, input logic [23:0] a, input logic [7:0] d,
                              output int done_cnt, output logic [7:0] got);
        int start;
        done_cnt = 0; got = '0;
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        for (int i = 0; i < 500 && !req_ready; i++) begin @(negedge clk); #1; end
        start = acc_count;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk("R12", "ready after accept", req_ready, 0);
        for (int i = 0; i < 500 && acc_count == start; i++) begin
            if (rd_done) begin done_cnt++; got = rd_data; end
            @(negedge clk); #1;
        end
        for (int i = 0; i < 3; i++) begin
            if (rd_done) begin done_cnt++; got = rd_data; end
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset;
        chk("R1", "ras_n", dram_ras_n, 2'b11);
        chk("R1", "cas_n", dram_cas_n, 1);
        chk("R1", "we_n", dram_we_n, 1);
        chk("R1", "dq_oe", dram_dq_oe, 0);
        chk("R1", "rd_done", rd_done, 0);
        chk("R1", "ready", req_ready, 1);
    endtask

    task automatic t_refresh_interval;
        int hi = 0;
        @(negedge clk); rst_n = 1'b1; #1;
        for (int i = 0; i < 100 && req_ready; i++) begin hi++; @(negedge clk); #1; end
        chk("R10", "idle ready cycles", hi, RI);
        chk("R10", "cas_n when ready drops", dram_cas_n, 1);
        @(negedge clk); #1;
        chk("R10", "cas_n one cycle later", dram_cas_n, 0);
        chk("R6", "rows closed at cas fall", dram_ras_n, 2'b11);
        wait_refreshes(1);
        chk("R7", "single-bank refresh pattern", m_rf_ras, 2'b10);
        chk("R6", "refresh order errors", order_err, 0);
    endtask

    task automatic t_write(input logic [23:0] a, input logic [7:0] d,
                           input logic [11:0] er, input logic [11:0] ec, input string rq);
        int dc; logic [7:0] g;
        run_access(1'b1, a, d, dc, g);
        chk(rq, "write row", m_row, er);
        chk(rq, "write col", m_col, ec);
        chk("R4", "we_n at ras fall", m_we_ras, 0);
        chk("R4", "oe at ras fall", m_oe_ras, 1);
        chk("R4", "data at cas fall", m_wd, d);
        chk("R4", "we_n at cas fall", m_we_cas, 0);
        chk("R11", "ras-to-cas cycles", m_ras_cnt, PH);
        chk("R3", "access order errors", order_err, 0);
        for (int i = 0; i < 500 && !req_ready; i++) begin @(negedge clk); #1; end
        chk("R4", "we_n released", dram_we_n, 1);
        chk("R4", "oe released", dram_dq_oe, 0);
    endtask

    task automatic t_read(input logic [23:0] a, input logic [11:0] er, input logic [11:0] ec,
                          input string rq);
        int dc; logic [7:0] g;
        run_access(1'b0, a, 8'h00, dc, g);
        chk(rq, "read row", m_row, er);
        chk(rq, "read col", m_col, ec);
        chk("R5", "we_n low seen", m_we_seen, 0);
        chk("R5", "oe seen", m_oe_seen, 0);
        chk("R5", "done pulses", dc, 1);
        chk("R5", "read byte", g, rd_base + 8'(PH));
        chk("R5", "rd_data held", rd_data, rd_base + 8'(PH));
    endtask

    task automatic t_abits;
        cfg_write(1'b0, 4'd8);
        t_write(24'h012345, 8'h3C, 12'h023, 12'h045, "R8");
        cfg_write(1'b0, 4'd13);
        t_read(24'h012345, 12'h023, 12'h045, "R8");
        cfg_write(1'b0, 4'd0);
        t_read(24'h012345, 12'h023, 12'h045, "R8");
        cfg_write(1'b0, 4'd1);
        t_write(24'h000007, 8'hC3, 12'h001, 12'h001, "R2");
    endtask

    task automatic t_banks;
        cfg_write(1'b1, 4'd2);
        wait_refreshes(2);
        chk("R9", "dual-bank refresh pattern", m_rf_ras, 2'b00);
        cfg_write(1'b1, 4'd3);
        wait_refreshes(2);
        chk("R9", "pattern after rejected 3", m_rf_ras, 2'b00);
        cfg_write(1'b1, 4'd0);
        wait_refreshes(2);
        chk("R9", "pattern after rejected 0", m_rf_ras, 2'b00);
        cfg_write(1'b0, 4'd12);
        t_write(24'hFFF001, 8'h81, 12'hFFF, 12'h001, "R2");
        chk("R7", "bank 1 low during access", bank_err, 0);
        cfg_write(1'b1, 4'd1);
        wait_refreshes(2);
        chk("R9", "back to single bank", m_rf_ras, 2'b10);
        chk("R6", "refresh order errors", order_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        t_refresh_interval();
        t_write(24'hABC123, 8'h5A, 12'hABC, 12'h123, "R2");
        t_read(24'hABC123, 12'hABC, 12'h123, "R3");
        t_abits();
        t_banks();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule